// File: doc/BRIEF.md
# AES-256 Round Key Expander

This block turns a 256-bit cipher key into the fifteen 128-bit round keys that an AES-256 data path consumes. A load strobe captures the key, and a small sequencer then writes one round key into an internal register bank on each clock. Fourteen cycles later the schedule is complete and stays put until a new key is accepted. A load strobe that arrives while the sequencer is working is dropped.

Downstream round logic fetches keys through a combinational read port addressed by round number. The block holds no cipher state of its own. Two copies can sit side by side with separate strobes, one for the data key and one for the tweak key, and they never interact. The S-box is computed in logic from its algebraic definition, a multiplicative inverse in GF(2^8) followed by the affine map, so no table is stored.

Top module: `aes256_key_expander`

## Requirements
- R1: When `key_vld_i` is high on a rising edge while `busy_o` is low, `key_i` is captured on that edge and `busy_o` is high from the next cycle.
- R2: After an accepted load, `busy_o` stays high for exactly 14 clock cycles and then returns low.
- R3: `done_o` is high for exactly one cycle, the last of the 14 busy cycles, and is never high while `busy_o` is low.
- R4: A `key_vld_i` pulse while `busy_o` is high has no effect: the schedule read back afterwards is the one for the key accepted earlier.
- R5: Round key 0 equals `key_i[255:128]` and round key 1 equals `key_i[127:0]`. Within each 128-bit round key, word 0 sits in bits [127:96] and word 3 in bits [31:0].
- R6: Round key n, for n from 2 to 14, is formed from round keys n-2 and n-1 by the standard AES-256 word recurrence. For even n, word 3 of key n-1 is rotated left by one byte, each byte is passed through the S-box, and the round constant 2^(n/2-1) is XORed into the top byte. For odd n, the S-box substitution is applied without rotation or constant. The result is XORed into word 0 of key n-2, and each later word is chained onto the one before it.
- R7: When `busy_o` is low, `rd_key_o` returns round key `rd_idx_i` for index values 0 to 14 in the same cycle. Index 15 returns all zeros.
- R8: Driving `rst_ni` low clears `busy_o`, `done_o` and `ready_o` at once, without waiting for a clock edge.
- R9: `ready_o` is low after reset and rises in the cycle after the first `done_o` pulse. It then stays high until the next reset.
- R10: A stored schedule stays unchanged while no load is accepted. A strobe held high through the cycle after `busy_o` falls is accepted and starts a new expansion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_vld_i | input | 1 | Load strobe for `key_i` |
| key_i | input | 256 | Cipher key |
| busy_o | output | 1 | Expansion in progress |
| done_o | output | 1 | One-cycle pulse on the last expansion cycle |
| ready_o | output | 1 | At least one schedule completed since reset |
| rd_idx_i | input | 4 | Round key index |
| rd_key_o | output | 128 | Round key selected by `rd_idx_i` |

## Verification
The expander is driven with three kinds of key:
- The all-ascending byte key has a published final round key. It pins the word order, the rotation and the round constants, so a swapped half or a wrong constant stands out.
- A dense pattern and an all-ones key exercise S-box inputs far from zero.
- A stream of changing keys behind a held-high strobe separates correct load-ignore and re-accept timing from a design that captures mid-run or misses the first idle cycle.

An asynchronous reset in the middle of a run shows whether the flags clear without a clock edge. The run then starts from a fresh state.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;
  localparam int KEY_W  = 256;
  localparam int BLK_W  = 128;
  localparam int WORD_W = 32;
  localparam int NUM_RK = 15;
  localparam int STEPS  = NUM_RK - 1;
  localparam int IDX_W  = $clog2(NUM_RK + 1);
  localparam int CNT_W  = $clog2(STEPS);

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // x^254 is the multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq, acc;
    sq  = gf_mul(a, a);
    acc = sq;
    for (int i = 0; i < 6; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sbox_f(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_kx_subword.sv
module aes_kx_subword
  import aes_kx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int NBYTES = WORD_W / 8;
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign word_o[8*g +: 8] = sbox_f(word_i[8*g +: 8]);
  end
endmodule

// File: rtl/aes_kx_step.sv
module aes_kx_step
  import aes_kx_pkg::*;
(
  input  logic [BLK_W-1:0] older_i,
  input  logic [BLK_W-1:0] newer_i,
  input  logic [IDX_W-1:0] rk_num_i,
  output logic [BLK_W-1:0] next_o
);
  localparam int NW = BLK_W / WORD_W;

  logic              even_step;
  logic [WORD_W-1:0] last_w, sub_in, sub_out, temp;
  logic [7:0]        rcon;
  logic [2:0]        rcon_sh;

  assign even_step = ~rk_num_i[0];
  assign last_w    = newer_i[WORD_W-1:0];
  assign sub_in    = even_step ? {last_w[WORD_W-9:0], last_w[WORD_W-1 -: 8]} : last_w;
  assign rcon_sh   = 3'(rk_num_i[IDX_W-1:1] - 1'b1);
  assign rcon      = even_step ? (8'h01 << rcon_sh) : 8'h00;

  aes_kx_subword u_sub (.word_i(sub_in), .word_o(sub_out));

  assign temp = sub_out ^ {rcon, {(WORD_W-8){1'b0}}};

  logic [WORD_W-1:0] w [NW];
  for (genvar g = 0; g < NW; g++) begin : g_word
    localparam int HI = BLK_W - 1 - g * WORD_W;
    if (g == 0) begin : g_first
      assign w[g] = older_i[HI -: WORD_W] ^ temp;
    end else begin : g_chain
      assign w[g] = older_i[HI -: WORD_W] ^ w[g-1];
    end
    assign next_o[HI -: WORD_W] = w[g];
  end
endmodule

// File: rtl/aes_kx_ctrl.sv
module aes_kx_ctrl
  import aes_kx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic             busy_q, ready_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = vld_i & ~busy_q;
  assign done_o = busy_q & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = ready_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/aes256_key_expander.sv
module aes256_key_expander
  import aes_kx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_vld_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ready_o,
  input  logic [3:0]       rd_idx_i,
  output logic [BLK_W-1:0] rd_key_o
);
  logic             load, busy;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] wr_idx;
  logic [BLK_W-1:0] older_q, newer_q, next_rk;
  logic [BLK_W-1:0] rk_q [NUM_RK];

  aes_kx_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(key_vld_i), .load_o(load),
    .busy_o(busy), .done_o(done_o), .ready_o(ready_o), .cnt_o(cnt)
  );

  assign wr_idx = IDX_W'(cnt) + 1'b1;

  aes_kx_step u_step (
    .older_i(older_q), .newer_i(newer_q), .rk_num_i(wr_idx), .next_o(next_rk)
  );

  // working pair: the two most recent round keys
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
      newer_q <= '0;
    end else if (load) begin
      older_q <= key_i[KEY_W-1 -: BLK_W];
      newer_q <= key_i[BLK_W-1:0];
    end else if (busy && cnt != '0) begin
      older_q <= newer_q;
      newer_q <= next_rk;
    end
  end

  for (genvar i = 0; i < NUM_RK; i++) begin : g_rk
    logic             we;
    logic [BLK_W-1:0] wd;
    if (i == 0) begin : g_k0
      assign we = load;
      assign wd = key_i[KEY_W-1 -: BLK_W];
    end else if (i == 1) begin : g_k1
      assign we = busy && (wr_idx == IDX_W'(1));
      assign wd = newer_q;
    end else begin : g_kn
      assign we = busy && (wr_idx == IDX_W'(i));
      assign wd = next_rk;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  rk_q[i] <= '0;
      else if (we)  rk_q[i] <= wd;
    end
  end

  assign rd_key_o = (int'(rd_idx_i) < NUM_RK) ? rk_q[rd_idx_i] : '0;
  assign busy_o   = busy;
endmodule

// File: rtl/aes_kx_checker.sv
module aes_kx_checker
  import aes_kx_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic key_vld_i,
  input logic busy_o,
  input logic done_o,
  input logic ready_o
);
  int unsigned run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  p_load_starts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_vld_i && !busy_o) |=> busy_o);

  p_done_at_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_len == STEPS - 1) |-> done_o);

  p_done_drops_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_done_pos_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && run_len == STEPS - 1));

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ready_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  p_ready_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(done_o));
endmodule

bind aes256_key_expander aes_kx_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .key_vld_i(key_vld_i),
  .busy_o(busy_o), .done_o(done_o), .ready_o(ready_o)
);

// File: tb/aes256_key_expander_tb.sv
module aes256_key_expander_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_vld = 1'b0;
  logic [255:0] key = '0;
  logic [3:0]   rd_idx = '0;
  logic         busy, done, ready;
  logic [127:0] rd_key;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  aes256_key_expander u_dut (
    .clk_i(clk), .rst_ni(rst_n), .key_vld_i(key_vld), .key_i(key),
    .busy_o(busy), .done_o(done), .ready_o(ready),
    .rd_idx_i(rd_idx), .rd_key_o(rd_key)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    int r = 0, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x << 1;
      if (x & 'h100) x = x ^ 'h11b;
    end
    return r[7:0];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] a);
    logic [7:0] inv = 8'h00, s;
    for (int c = 1; c < 256; c++) if (m_mul(a, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return s ^ 8'h63;
  endfunction

  function automatic logic [31:0] m_sub(input logic [31:0] w);
    return {m_sbox(w[31:24]), m_sbox(w[23:16]), m_sbox(w[15:8]), m_sbox(w[7:0])};
  endfunction

  logic [127:0] m_rk [15];
  logic         m_busy = 0, m_ready = 0;
  int           m_cnt = 0;

  task automatic m_expand(input logic [255:0] k);
    logic [31:0] w [60];
    logic [31:0] t;
    logic [7:0]  rc;
    for (int i = 0; i < 8; i++) w[i] = k[255 - 32*i -: 32];
    rc = 8'h01;
    for (int i = 8; i < 60; i++) begin
      t = w[i-1];
      if (i % 8 == 0) begin
        t = m_sub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end else if (i % 8 == 4) begin
        t = m_sub(t);
      end
      w[i] = w[i-8] ^ t;
    end
    for (int r = 0; r < 15; r++) m_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 13) begin m_busy = 0; m_ready = 1; end
      else m_cnt++;
    end else if (key_vld) begin
      m_busy = 1; m_cnt = 0;
      m_expand(key);
    end
  end

  // per-cycle comparison of the handshake outputs
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (busy !== m_busy || done !== (m_busy && m_cnt == 13) || ready !== m_ready) begin
        n_fail++;
        $display("FAIL R1/R2/R3/R9 handshake: busy=%b done=%b ready=%b exp %b %b %b",
                 busy, done, ready, m_busy, (m_busy && m_cnt == 13), m_ready);
      end
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic load(input logic [255:0] k);
    @(negedge clk);
    key = k; key_vld = 1'b1;
    @(negedge clk);
    key_vld = 1'b0; key = ~k;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 15; i++) begin
      rd_idx = 4'(i); #1;
      check(req, rd_key, m_rk[i]);
    end
  endtask

  localparam logic [255:0] K_A = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [255:0] K_B = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1;
    check("R8 reset flags", {125'h0, busy, done, ready}, 128'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready low after reset", {127'h0, ready}, 128'h0);

    // known vector: halves and final round key
    load(K_A);
    wait_idle();
    read_all("R5/R6 known key");
    rd_idx = 4'd0; #1; check("R5 rk0 high half", rd_key, K_A[255:128]);
    rd_idx = 4'd1; #1; check("R5 rk1 low half", rd_key, K_A[127:0]);
    rd_idx = 4'd14; #1; check("R6 final key", rd_key, 128'h24fc79ccbf0979e9371ac23c6d68de36);
    rd_idx = 4'd15; #1; check("R7 index 15 zero", rd_key, 128'h0);

    // schedule retained while idle
    repeat (20) @(negedge clk);
    read_all("R10 retained");

    // strobe mid-run ignored
    load(K_B);
    repeat (4) @(negedge clk);
    key = {8{32'hdeadbeef}}; key_vld = 1'b1;
    @(negedge clk);
    key_vld = 1'b0;
    wait_idle();
    read_all("R4 ignore during busy");
    rd_idx = 4'd0; #1; check("R4 rk0 kept", rd_key, K_B[255:128]);

    // held strobe with changing key: re-accept right after busy drops
    @(negedge clk);
    key_vld = 1'b1;
    for (int c = 0; c < 20; c++) begin
      key = {8{$urandom()}};
      @(negedge clk);
    end
    key_vld = 1'b0;
    wait_idle();
    read_all("R10 back-to-back");

    load({256{1'b1}});
    wait_idle();
    read_all("R6 all ones");

    // async reset mid-run
    load(K_A);
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R8 async clear", {125'h0, busy, done, ready}, 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready cleared by reset", {127'h0, ready}, 128'h0);
    load(K_B);
    wait_idle();
    read_all("R1 after reset");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule